// File: doc/BRIEF.md
# Self-Test Link Pattern Checker

This block sits at the receive end of a serial video link. It checks the link while a built-in self-test runs. The receiver is placed in self-test first. The far-end transmitter then sends a fixed all-zero payload. Each recovered word that arrives while the receiver is locked is compared against zero. Words that do not match are counted, and a pass flag drops on the cycle after the first bad word.

While the test runs, the normal pixel, sync and data-enable outputs are taken over by a simultaneous-switching pattern. This pattern stresses the output drivers. When self-test is released, the outputs return to the received video. The pass flag and the error count keep the result of the run that just finished.

A result-clear input wipes the held result between runs. It has no effect while a test is in progress.

Top module: `lnk_selftest_chk`

## Requirements
- R1: On the first clock edge at which `test_en` is sampled high after being low, the error count becomes 0 and `pass_o` becomes 1.
- R2: A word is compared only at an edge where `test_en` was also high at the previous edge and `rx_lock` and `word_vld` are both high. Words sampled with `rx_lock` low, with `word_vld` low, or at the entry edge never change the count.
- R3: A compared word is a mismatch when any of its bits is 1. Each mismatching word adds exactly one to `err_cnt_o`, whatever the number of bits set.
- R4: `err_cnt_o` is 8 bits wide. It saturates at 255 and never wraps.
- R5: `pass_o` goes low on the edge that counts a mismatch. It stays low for the rest of that test run.
- R6: While `test_en` is sampled high, the 27 outputs (`pix_out`, `hs_out`, `vs_out`, `de_out`) are all 1 after the first such edge. They then invert together on every following edge.
- R7: While `test_en` is sampled low, the outputs equal `pix_in`, `hs_in`, `vs_in` and `de_in` from the same edge, one register late.
- R8: After `test_en` falls, `pass_o` and `err_cnt_o` hold their final values until the next test entry or a result clear. Incoming words are ignored during this time.
- R9: `res_clr` sampled with `test_en` low sets the count to 0 and `pass_o` to 0. While `test_en` is high, `res_clr` is ignored.
- R10: While `rst_n` is low, `err_cnt_o`, `pass_o` and all pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en | input | 1 | Self-test enable |
| rx_lock | input | 1 | Receiver locked to serial stream |
| word_vld | input | 1 | Recovered word strobe |
| word_data | input | 24 | Recovered payload word |
| res_clr | input | 1 | Clear held result (outside test) |
| pix_in | input | 24 | Received pixel data |
| hs_in | input | 1 | Received horizontal sync |
| vs_in | input | 1 | Received vertical sync |
| de_in | input | 1 | Received data enable |
| pix_out | output | 24 | Pixel output |
| hs_out | output | 1 | Horizontal sync output |
| vs_out | output | 1 | Vertical sync output |
| de_out | output | 1 | Data enable output |
| pass_o | output | 1 | Live / held pass flag |
| err_cnt_o | output | 8 | Mismatch count |

## Verification
A wrong entry flag or phase register shows up at the pins within one clock. The pixel bus either fails to start at all-ones or fails to invert on the next edge. A broken compare qualifier or saturation path shows up in the error count on the edge after the offending word, through a missing increment, an extra increment or a wrap to zero. State lost after the test ends shows up as a held flag or count that drifts while incoming words are still arriving.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  // saturating increment of the mismatch count
  function automatic cnt_t sat_inc(input cnt_t v);
    if (v == cnt_t'(CNT_MAX)) return v;
    return v + cnt_t'(1);
  endfunction

  // level of every switching output for a given phase
  function automatic logic sso_level(input logic phase);
    return ~phase;
  endfunction
endpackage

// File: rtl/lst_word_cmp.sv
module lst_word_cmp #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              rx_lock,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_data,
  output logic              entry_evt,
  output logic              err_evt
);
  logic test_q;
  logic running;
  logic word_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) test_q <= 1'b0;
    else        test_q <= test_en;
  end

  assign entry_evt = test_en & ~test_q;
  assign running   = test_en & test_q;
  assign word_bad  = |word_data;
  assign err_evt   = running & rx_lock & word_vld & word_bad;
endmodule

// File: rtl/lst_err_track.sv
module lst_err_track
  import lst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic entry_evt,
  input  logic clr_evt,
  input  logic err_evt,
  output cnt_t cnt_q,
  output logic pass_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else if (entry_evt) begin
      cnt_q  <= '0;
      pass_q <= 1'b1;
    end else if (clr_evt) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else if (err_evt) begin
      cnt_q  <= sat_inc(cnt_q);
      pass_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lst_sso_gen.sv
module lst_sso_gen
  import lst_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             de_in,
  output logic [PIX_W-1:0] pix_out,
  output logic             hs_out,
  output logic             vs_out,
  output logic             de_out
);
  localparam int unsigned BUS_W = PIX_W + 3;

  logic             phase_q;
  logic [BUS_W-1:0] bus_q;
  logic [BUS_W-1:0] bus_d;

  always_comb begin
    if (test_en) bus_d = {BUS_W{sso_level(phase_q)}};
    else         bus_d = {pix_in, hs_in, vs_in, de_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      bus_q   <= '0;
    end else begin
      phase_q <= test_en ? ~phase_q : 1'b0;
      bus_q   <= bus_d;
    end
  end

  assign pix_out = bus_q[BUS_W-1:3];
  assign hs_out  = bus_q[2];
  assign vs_out  = bus_q[1];
  assign de_out  = bus_q[0];
endmodule

// File: rtl/lnk_selftest_chk.sv
module lnk_selftest_chk
  import lst_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              rx_lock,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_data,
  input  logic              res_clr,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              de_in,
  output logic [PIX_W-1:0]  pix_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic              de_out,
  output logic              pass_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic entry_evt;
  logic err_evt;
  logic clr_evt;

  assign clr_evt = res_clr & ~test_en;

  lst_word_cmp #(.WORD_W(WORD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .rx_lock(rx_lock),
    .word_vld(word_vld), .word_data(word_data),
    .entry_evt(entry_evt), .err_evt(err_evt)
  );

  lst_err_track u_trk (
    .clk(clk), .rst_n(rst_n), .entry_evt(entry_evt), .clr_evt(clr_evt),
    .err_evt(err_evt), .cnt_q(err_cnt_o), .pass_q(pass_o)
  );

  lst_sso_gen #(.PIX_W(PIX_W)) u_sso (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
  );
endmodule

// File: rtl/lst_chk.sv
module lst_chk #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_en,
  input logic             rx_lock,
  input logic             res_clr,
  input logic             entry_evt,
  input logic             err_evt,
  input logic [PIX_W-1:0] pix_out,
  input logic             hs_out,
  input logic             de_out,
  input logic             pass_o,
  input logic [7:0]       err_cnt_o
);
  a_r1_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt |=> (err_cnt_o == 8'd0 && pass_o));

  a_r2_no_count_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_lock && !entry_evt && !(res_clr && !test_en)) |=> $stable(err_cnt_o));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && err_cnt_o != 8'hFF) |=> (err_cnt_o == $past(err_cnt_o) + 8'd1));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && err_cnt_o == 8'hFF) |=> (err_cnt_o == 8'hFF));

  a_r5_pass_drops: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !pass_o);

  a_r6_sso_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && $past(test_en)) |=> (pix_out == ~$past(pix_out) && hs_out == de_out && de_out == pix_out[0]));

  a_r8_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en && !res_clr) |=> ($stable(pass_o) && $stable(err_cnt_o)));
endmodule

bind lnk_selftest_chk lst_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .rx_lock(rx_lock),
  .res_clr(res_clr), .entry_evt(entry_evt), .err_evt(err_evt),
  .pix_out(pix_out), .hs_out(hs_out), .de_out(de_out),
  .pass_o(pass_o), .err_cnt_o(err_cnt_o)
);

// File: tb/lnk_selftest_chk_tb.sv
module lnk_selftest_chk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_en = 1'b0, rx_lock = 1'b0, word_vld = 1'b0, res_clr = 1'b0;
  logic [23:0] word_data = '0, pix_in = '0;
  logic        hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic [23:0] pix_out;
  logic        hs_out, vs_out, de_out, pass_o;
  logic [7:0]  err_cnt_o;

  int checks = 0, failures = 0;
  // bench-side expectation state
  int   m_cnt = 0;
  logic m_pass = 1'b0, m_prev = 1'b0, m_ph = 1'b0;
  logic [26:0] m_bus = '0;

  always #5 clk = ~clk;

  lnk_selftest_chk u_dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .rx_lock(rx_lock),
    .word_vld(word_vld), .word_data(word_data), .res_clr(res_clr),
    .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out),
    .pass_o(pass_o), .err_cnt_o(err_cnt_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: update expectations from the driven inputs, then sample after the edge
  task automatic step();
    logic entry, run;
    entry = test_en & ~m_prev;
    run   = test_en & m_prev;
    if (entry) begin m_cnt = 0; m_pass = 1'b1; end
    else if (res_clr && !test_en) begin m_cnt = 0; m_pass = 1'b0; end
    else if (run && rx_lock && word_vld && word_data != 0) begin
      m_cnt = (m_cnt >= 255) ? 255 : m_cnt + 1;
      m_pass = 1'b0;
    end
    if (test_en) begin m_bus = m_ph ? 27'h0 : 27'h7FFFFFF; m_ph = ~m_ph; end
    else begin m_bus = {pix_in, hs_in, vs_in, de_in}; m_ph = 1'b0; end
    m_prev = test_en;
    @(posedge clk); #1;
  endtask

  task automatic check_all(input string tag);
    check({tag, " cnt"},  {24'h0, err_cnt_o}, m_cnt);
    check({tag, " pass"}, {31'h0, pass_o},    {31'h0, m_pass});
    check({tag, " bus"},  {5'h0, pix_out, hs_out, vs_out, de_out}, {5'h0, m_bus});
  endtask

  initial begin : watchdog
    #1500000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset cnt",  {24'h0, err_cnt_o}, 0);
    check("R10 reset pass", {31'h0, pass_o}, 0);
    check("R10 reset bus",  {5'h0, pix_out, hs_out, vs_out, de_out}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R7 passthrough sweep
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      pix_in = 24'h1 << (i % 24) ^ 24'(i * 24'h3A5);
      {hs_in, vs_in, de_in} = 3'(i);
      step(); check_all("R7 passthrough");
    end

    // R1 entry with a bad word present at the entry edge (R2 entry ignored)
    @(negedge clk);
    test_en = 1'b1; rx_lock = 1'b1; word_vld = 1'b1; word_data = 24'hFFFFFF;
    step(); check_all("R1 entry R2 entry-edge");

    // R2 unlocked / no strobe; R6 switching
    @(negedge clk); rx_lock = 1'b0;
    for (int i = 0; i < 6; i++) begin step(); check_all("R2 unlocked R6 sso"); end
    @(negedge clk); rx_lock = 1'b1; word_vld = 1'b0;
    for (int i = 0; i < 6; i++) begin step(); check_all("R2 no strobe R6 sso"); end
    @(negedge clk); word_vld = 1'b1; word_data = '0;
    for (int i = 0; i < 8; i++) begin step(); check_all("R3 zero words"); end

    // R3 walking single bit then multi-bit; R5 pass drop
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); word_data = 24'h1 << i;
      step(); check_all("R3 R5 single-bit error");
    end
    @(negedge clk); word_data = 24'hA5A5A5;
    step(); check_all("R3 multi-bit error");
    @(negedge clk); word_data = '0;
    step(); check_all("R5 pass stays low");

    // R4 saturation
    @(negedge clk); word_data = 24'h800001;
    for (int i = 0; i < 260; i++) begin step(); check_all("R4 saturate"); end

    // R9 clear ignored during test
    @(negedge clk); res_clr = 1'b1; word_data = '0;
    step(); check_all("R9 clear ignored in test");
    @(negedge clk); res_clr = 1'b0;

    // R8 hold after exit, words ignored
    @(negedge clk); test_en = 1'b0; word_data = 24'h000100; pix_in = 24'h123456;
    for (int i = 0; i < 5; i++) begin step(); check_all("R8 hold R7 return"); end

    // R9 clear outside test
    @(negedge clk); res_clr = 1'b1;
    step(); check_all("R9 clear");
    @(negedge clk); res_clr = 1'b0;
    step(); check_all("R9 after clear");

    // second run, clean: pass held high after exit (R8)
    @(negedge clk); test_en = 1'b1; word_data = '0;
    for (int i = 0; i < 10; i++) begin step(); check_all("R1 R6 clean run"); end
    @(negedge clk); test_en = 1'b0;
    for (int i = 0; i < 4; i++) begin step(); check_all("R8 clean hold"); end

    // reset mid-test
    @(negedge clk); test_en = 1'b1; word_data = 24'h000004;
    for (int i = 0; i < 4; i++) step();
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R10 reset again cnt", {24'h0, err_cnt_o}, 0);
    check("R10 reset again pass", {31'h0, pass_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule